// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block watches the downstream side of an I2C multiplexer or bus buffer for a bus held low. The bus levels and the channel enables arrive as digitised inputs. The block keeps a watchdog counting system clock cycles. The watchdog restarts every time every enabled downstream channel shows SCL and SDA high in the same sample. If that does not happen within the timeout window, the block declares a stuck bus and drives its active-low fault flag low.

A mode input selects what happens next. With automatic disconnection on, the controller opens the upstream-to-downstream path. It then clocks SCL on the channels that were enabled when the fault fired, to shake loose a slave that is holding SDA. Clocking ends as soon as SDA is seen released, or after a fixed number of pulses. A STOP condition follows. With automatic disconnection off, the fault flag is the only effect.

The path comes back, and the fault flag clears, only after all enables have been low and then at least one enable rises. All bus outputs are pull-down enables: 0 pulls the line low, 1 releases it. The timeout, the recovery half-period and the pulse limit are parameters counted in clock cycles. The defaults assume a 50 MHz clock: a 45 ms timeout and a recovery clock of about 100 kHz.

Top module: `busunstick_ctrl`

## Requirements
- R1: After reset, connect_o is 1, fault_n_o is 1, and every bit of scl_rel_o and sda_rel_o is 1 (released).
- R2: All inputs pass through two synchronizer flops. The watchdog counts only while connect_o is 1 and at least one synchronized enable is 1. It restarts on any synchronized sample in which every enabled channel has SCL=1 and SDA=1. A timeout occurs on the TIMEOUT_CYC-th consecutive counted sample without such a pair. Channels whose enable is 0 are ignored.
- R3: A timeout drives fault_n_o to 0 on the clock edge that follows it.
- R4: If the synchronized auto_disc_i is 1 at timeout, connect_o goes to 0 on the same edge as fault_n_o. The enable pattern at that moment is latched as the recovery mask. Only channels in the mask are ever pulled low during recovery.
- R5: Recovery pulses start with the first cycle after the fault edge. Each pulse holds the masked SCL outputs at 0 for HALF_CYC cycles and then at 1 for HALF_CYC cycles.
- R6: At the last cycle of each pulse's high half, clocking ends if the synchronized SDA is 1 on every masked channel, or if MAX_PULSES pulses are done. Counted as falling SCL edges, at most MAX_PULSES+1 occur, including the start of the STOP condition.
- R7: The STOP condition pulls masked SCL and SDA low for HALF_CYC cycles. It then releases SCL with SDA still low for HALF_CYC cycles, and then releases SDA. After that, all outputs stay released while the block waits.
- R8: If the synchronized auto_disc_i is 0 at timeout, only fault_n_o falls. connect_o stays 1, and no SCL or SDA output is pulled low.
- R9: After a fault, connection and fault_n_o are restored only when, after the fault, a sample shows all synchronized enables at 0, and a later sample shows a 0-to-1 change on any enable. An enable rise without that earlier all-low sample changes nothing.
- R10: A reconnect sequence that completes during recovery clocking or the STOP condition ends recovery at once. connect_o and fault_n_o return to 1, and all outputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | NCH | Per-channel downstream enables |
| auto_disc_i | input | 1 | 1 enables automatic disconnect, clocking and STOP on a fault |
| scl_i | input | NCH | Digitised downstream SCL level per channel |
| sda_i | input | NCH | Digitised downstream SDA level per channel |
| connect_o | output | 1 | 1 connects the upstream bus to the enabled downstream channels |
| fault_n_o | output | 1 | Stuck-bus fault flag, active low |
| scl_rel_o | output | NCH | Per-channel SCL pull-down enable, 0 pulls low |
| sda_rel_o | output | NCH | Per-channel SDA pull-down enable, 0 pulls low |

## Verification
The hardest situations to reach from the ports are an early end to recovery and a reconnect that lands in the middle of recovery. In the first, a slave lets go of SDA partway through clocking, and the exit must fall on the correct pulse boundary after the synchronizer delay. In the second, the enable sequence completes while pulses are still running. The bench wires each output back into the matching input through a model of a slave that holds SDA low. That slave can be told to release after a chosen number of SCL falling edges. The bench also drops and raises the enables while recovery pulses are still running, and a cycle-accurate behavioural model follows every output on every clock.

// File: rtl/busunstick_pkg.sv
package busunstick_pkg;
  typedef enum logic [1:0] {
    ST_LINKED   = 2'd0,
    ST_CLOCKING = 2'd1,
    ST_STOP     = 2'd2,
    ST_WAIT     = 2'd3
  } rec_state_t;
endpackage

// File: rtl/busunstick_sync.sv
module busunstick_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/busunstick_wdog.sv
module busunstick_wdog #(
  parameter int TIMEOUT_CYC = 2_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic bus_idle_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;

  // fires on the TIMEOUT_CYC-th counted sample without an idle pair
  assign timeout_o = run_i && !bus_idle_i && (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || bus_idle_i || timeout_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/busunstick_seq.sv
module busunstick_seq
  import busunstick_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int HALF_CYC   = 250,
  parameter int MAX_PULSES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_s_i,
  input  logic [NCH-1:0] sda_s_i,
  input  logic           disc_s_i,
  input  logic           timeout_i,
  output logic           connect_o,
  output logic           fault_n_o,
  output logic           scl_low_o,
  output logic           sda_low_o,
  output logic [NCH-1:0] mask_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int PW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;

  rec_state_t     state_q;
  logic [HW-1:0]  hc_q;
  logic [PW-1:0]  pc_q;
  logic [NCH-1:0] en_prev_q;
  logic           arm_q;
  logic           rejoin;
  logic           sda_ok;
  logic           half_end;

  assign rejoin   = arm_q && |(en_s_i & ~en_prev_q);
  assign sda_ok   = &(~mask_o | sda_s_i);
  assign half_end = (hc_q == HW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LINKED;
      connect_o <= 1'b1;
      fault_n_o <= 1'b1;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      mask_o    <= '0;
      hc_q      <= '0;
      pc_q      <= '0;
      en_prev_q <= '0;
      arm_q     <= 1'b0;
    end else begin
      en_prev_q <= en_s_i;
      if (state_q == ST_LINKED) begin
        if (timeout_i) begin
          fault_n_o <= 1'b0;
          arm_q     <= 1'b0;
          if (disc_s_i) begin
            connect_o <= 1'b0;
            state_q   <= ST_CLOCKING;
            mask_o    <= en_s_i;
            scl_low_o <= 1'b1;
            hc_q      <= '0;
            pc_q      <= '0;
          end
        end else if (!fault_n_o) begin
          if (rejoin) begin
            fault_n_o <= 1'b1;
            arm_q     <= 1'b0;
          end else if (en_s_i == '0) begin
            arm_q <= 1'b1;
          end
        end
      end else if (rejoin) begin
        state_q   <= ST_LINKED;
        connect_o <= 1'b1;
        fault_n_o <= 1'b1;
        arm_q     <= 1'b0;
        scl_low_o <= 1'b0;
        sda_low_o <= 1'b0;
      end else begin
        if (en_s_i == '0) arm_q <= 1'b1;
        unique case (state_q)
          ST_CLOCKING: begin
            if (half_end) begin
              hc_q <= '0;
              if (scl_low_o) begin
                scl_low_o <= 1'b0;
              end else if (sda_ok || pc_q == PW'(MAX_PULSES - 1)) begin
                state_q   <= ST_STOP;
                scl_low_o <= 1'b1;
                sda_low_o <= 1'b1;
              end else begin
                pc_q      <= pc_q + PW'(1);
                scl_low_o <= 1'b1;
              end
            end else begin
              hc_q <= hc_q + HW'(1);
            end
          end
          ST_STOP: begin
            if (half_end) begin
              hc_q <= '0;
              if (scl_low_o) begin
                scl_low_o <= 1'b0;
              end else begin
                sda_low_o <= 1'b0;
                state_q   <= ST_WAIT;
              end
            end else begin
              hc_q <= hc_q + HW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/busunstick_ctrl.sv
module busunstick_ctrl #(
  parameter int NCH         = 4,
  parameter int TIMEOUT_CYC = 2_250_000,
  parameter int HALF_CYC    = 250,
  parameter int MAX_PULSES  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_i,
  input  logic           auto_disc_i,
  input  logic [NCH-1:0] scl_i,
  input  logic [NCH-1:0] sda_i,
  output logic           connect_o,
  output logic           fault_n_o,
  output logic [NCH-1:0] scl_rel_o,
  output logic [NCH-1:0] sda_rel_o
);
  localparam int SW = 3 * NCH + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {NCH{1'b0}}, {NCH{1'b1}}, {NCH{1'b1}}};

  logic [SW-1:0]  raw_bus;
  logic [SW-1:0]  sync_bus;
  logic           disc_s;
  logic [NCH-1:0] en_s;
  logic [NCH-1:0] scl_s;
  logic [NCH-1:0] sda_s;
  logic           bus_idle;
  logic           wd_run;
  logic           wd_timeout;
  logic           scl_low;
  logic           sda_low;
  logic [NCH-1:0] mask;

  assign raw_bus = {auto_disc_i, en_i, scl_i, sda_i};

  busunstick_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  assign {disc_s, en_s, scl_s, sda_s} = sync_bus;

  assign bus_idle = &(~en_s | (scl_s & sda_s));
  assign wd_run   = connect_o && (|en_s);

  busunstick_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (wd_run),
    .bus_idle_i (bus_idle),
    .timeout_o  (wd_timeout)
  );

  busunstick_seq #(.NCH(NCH), .HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s_i    (en_s),
    .sda_s_i   (sda_s),
    .disc_s_i  (disc_s),
    .timeout_i (wd_timeout),
    .connect_o (connect_o),
    .fault_n_o (fault_n_o),
    .scl_low_o (scl_low),
    .sda_low_o (sda_low),
    .mask_o    (mask)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign scl_rel_o[g] = ~(scl_low & mask[g]);
    assign sda_rel_o[g] = ~(sda_low & mask[g]);
  end
endmodule

// File: rtl/busunstick_chk.sv
module busunstick_chk #(
  parameter int NCH        = 4,
  parameter int MAX_PULSES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           connect_o,
  input logic           fault_n_o,
  input logic [NCH-1:0] scl_rel_o,
  input logic [NCH-1:0] sda_rel_o,
  input logic           wd_timeout
);
  logic [NCH-1:0] scl_prev_q;
  int             falls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= '1;
      falls_q    <= 0;
    end else begin
      scl_prev_q <= scl_rel_o;
      if (connect_o) falls_q <= 0;
      else if (|(scl_prev_q & ~scl_rel_o)) falls_q <= falls_q + 1;
    end
  end

  a_r3_fault_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n_o) |-> $past(wd_timeout));

  a_r4_disc_implies_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !connect_o |-> !fault_n_o);

  a_r5_scl_only_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
    (~&scl_rel_o) |-> !connect_o);

  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    falls_q <= MAX_PULSES + 1);

  a_r7_sda_only_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
    (~&sda_rel_o) |-> !connect_o);

  a_r8_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n_o && connect_o) |-> (&scl_rel_o && &sda_rel_o));

  a_r9_rejoin_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_o) |-> fault_n_o);
endmodule

bind busunstick_ctrl busunstick_chk #(.NCH(NCH), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .connect_o  (connect_o),
  .fault_n_o  (fault_n_o),
  .scl_rel_o  (scl_rel_o),
  .sda_rel_o  (sda_rel_o),
  .wd_timeout (wd_timeout)
);

// File: tb/sim_busunstick_ctrl.sv
module sim_busunstick_ctrl;
  localparam int N  = 4;
  localparam int TO = 40;
  localparam int H  = 3;
  localparam int MP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] en = '0;
  logic disc = 1'b0;
  logic [N-1:0] hold_sda = '0;
  logic [N-1:0] hold_scl = '0;
  logic [N-1:0] scl_raw, sda_raw;
  logic connect_o, fault_n_o;
  logic [N-1:0] scl_rel_o, sda_rel_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";

  int falls_scl [N];
  int falls_sda [N];
  int base_scl [N];
  int base_sda [N];
  int rel_after = 0;
  logic slave_free;

  always #5 clk = ~clk;

  assign slave_free = (rel_after != 0) && ((falls_scl[0] - base_scl[0]) >= rel_after);
  assign scl_raw = scl_rel_o & ~hold_scl;
  assign sda_raw = sda_rel_o & ~(hold_sda & ~{{(N-1){1'b0}}, slave_free});

  busunstick_ctrl #(.NCH(N), .TIMEOUT_CYC(TO), .HALF_CYC(H), .MAX_PULSES(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .auto_disc_i(disc),
    .scl_i(scl_raw), .sda_i(sda_raw),
    .connect_o(connect_o), .fault_n_o(fault_n_o),
    .scl_rel_o(scl_rel_o), .sda_rel_o(sda_rel_o)
  );

  // behavioural reference: 0 linked, 1 clocking, 2 stop, 3 waiting
  int m_st, m_cnt, m_e;
  logic m_conn, m_fn, m_arm, m_run;
  logic [N-1:0] m_mask, m_prev;
  logic [3*N:0] q1, q2;
  logic [N-1:0] e_s, c_s, d_s;
  logic ds, idle, rejoin, tmo, okk;
  localparam logic [3*N:0] QRST = {1'b0, {N{1'b0}}, {N{1'b1}}, {N{1'b1}}};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_e = 0; m_conn = 1; m_fn = 1; m_arm = 0;
      m_mask = '0; m_prev = '0; q1 = QRST; q2 = QRST; m_run = 0;
    end else begin
      m_run = 1;
      {ds, e_s, c_s, d_s} = q2;
      q2 = q1;
      q1 = {disc, en, scl_raw, sda_raw};
      rejoin = m_arm && ((e_s & ~m_prev) != 0);
      idle = 1;
      for (int i = 0; i < N; i++) if (e_s[i] && !(c_s[i] && d_s[i])) idle = 0;
      if (m_st == 0) begin
        tmo = 0;
        if (e_s != 0 && !idle) begin
          if (m_cnt == TO - 1) begin tmo = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
        if (tmo) begin
          m_fn = 0; m_arm = 0;
          if (ds) begin m_conn = 0; m_st = 1; m_mask = e_s; m_e = 0; end
        end else if (!m_fn) begin
          if (rejoin) begin m_fn = 1; m_arm = 0; end
          else if (e_s == 0) m_arm = 1;
        end
      end else begin
        m_cnt = 0;
        if (rejoin) begin
          m_st = 0; m_conn = 1; m_fn = 1; m_arm = 0;
        end else begin
          if (e_s == 0) m_arm = 1;
          if (m_st == 1) begin
            okk = ((~m_mask | d_s) == '1);
            if ((m_e % (2*H)) == 2*H - 1 && (okk || (m_e / (2*H)) == MP - 1)) begin
              m_st = 2; m_e = 0;
            end else m_e = m_e + 1;
          end else if (m_st == 2) begin
            if (m_e == 2*H - 1) m_st = 3;
            else m_e = m_e + 1;
          end
        end
      end
      m_prev = e_s;
    end
  end

  logic exp_scl_low, exp_sda_low;
  logic [N-1:0] exp_scl, exp_sda, prev_scl, prev_sda;
  initial begin prev_scl = '1; prev_sda = '1; end

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (prev_scl[i] && !scl_rel_o[i]) falls_scl[i] = falls_scl[i] + 1;
      if (prev_sda[i] && !sda_rel_o[i]) falls_sda[i] = falls_sda[i] + 1;
    end
    prev_scl = scl_rel_o;
    prev_sda = sda_rel_o;
    if (m_run) begin
      exp_scl_low = (m_st == 1 && (m_e % (2*H)) < H) || (m_st == 2 && m_e < H);
      exp_sda_low = (m_st == 2);
      exp_scl = ~({N{exp_scl_low}} & m_mask);
      exp_sda = ~({N{exp_sda_low}} & m_mask);
      n_chk = n_chk + 1;
      if (connect_o !== m_conn || fault_n_o !== m_fn ||
          scl_rel_o !== exp_scl || sda_rel_o !== exp_sda) begin
        n_fail = n_fail + 1;
        $display("FAIL %s model cycle %0d: act conn=%b fn=%b scl=%b sda=%b exp conn=%b fn=%b scl=%b sda=%b",
                 cur_req, cyc, connect_o, fault_n_o, scl_rel_o, sda_rel_o,
                 m_conn, m_fn, exp_scl, exp_sda);
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: run did not finish, act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < N; i++) begin
      base_scl[i] = falls_scl[i];
      base_sda[i] = falls_sda[i];
    end
  endtask

  task automatic wait_fault();
    for (int i = 0; i < 500; i++) begin
      if (!fault_n_o) break;
      @(negedge clk);
    end
  endtask

  task automatic rejoin_seq(input logic [N-1:0] back);
    en = '0; tick(4);
    en = back; tick(5);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      falls_scl[i] = 0; falls_sda[i] = 0; base_scl[i] = 0; base_sda[i] = 0;
    end
    tick(5);
    cur_req = "R1";
    check("R1 connect after reset", int'(connect_o), 1);
    check("R1 fault_n after reset", int'(fault_n_o), 1);
    check("R1 scl released", int'(scl_rel_o), 15);
    check("R1 sda released", int'(sda_rel_o), 15);
    rst_n = 1'b1;
    tick(2);

    // idle bus, one channel enabled
    cur_req = "R2";
    en = 4'b0001; tick(200);
    check("R2 idle bus no fault", int'(fault_n_o), 1);

    // short low bursts that stay under the timeout
    for (int k = 0; k < 4; k++) begin
      hold_sda[0] = 1'b1; tick(30);
      hold_sda[0] = 1'b0; tick(5);
    end
    check("R2 short bursts no fault", int'(fault_n_o), 1);

    // stuck line on a disabled channel is ignored
    en = 4'b0010; hold_sda[0] = 1'b1; tick(200);
    check("R2 disabled channel ignored", int'(fault_n_o), 1);
    hold_sda[0] = 1'b0; tick(5);

    // full recovery with no release
    cur_req = "R4/R5/R6/R7";
    disc = 1'b1; en = 4'b0011; tick(5);
    snap();
    hold_sda[0] = 1'b1;
    wait_fault();
    check("R3 fault asserted", int'(fault_n_o), 0);
    check("R4 disconnected with fault", int'(connect_o), 0);
    check("R5 first low half", int'(scl_rel_o[0]), 0);
    tick(H);
    check("R5 high half after HALF_CYC", int'(scl_rel_o[0]), 1);
    tick(150);
    check("R6 ch0 scl falls = MAX_PULSES+1", falls_scl[0] - base_scl[0], MP + 1);
    check("R4 ch1 in mask", falls_scl[1] - base_scl[1], MP + 1);
    check("R4 ch2 untouched", falls_scl[2] - base_scl[2], 0);
    check("R7 one sda low on ch0", falls_sda[0] - base_sda[0], 1);
    check("R7 sda released after stop", int'(sda_rel_o), 15);
    check("R7 scl released after stop", int'(scl_rel_o), 15);

    // rise without prior all-low sample does nothing
    cur_req = "R9";
    hold_sda[0] = 1'b0;
    en = 4'b0111; tick(10);
    check("R9 rise without all-low", int'(connect_o), 0);
    rejoin_seq(4'b0001);
    check("R9 reconnected", int'(connect_o), 1);
    check("R9 fault cleared", int'(fault_n_o), 1);

    // slave lets go after three clocks
    cur_req = "R6";
    tick(5);
    snap();
    rel_after = 3;
    hold_sda[0] = 1'b1;
    wait_fault();
    tick(100);
    check("R6 early exit after 3 pulses", falls_scl[0] - base_scl[0], 4);
    hold_sda[0] = 1'b0; rel_after = 0;
    rejoin_seq(4'b0001);
    check("R9 reconnected after early exit", int'(connect_o), 1);

    // flag-only mode
    cur_req = "R8";
    disc = 1'b0; tick(5);
    snap();
    hold_sda[0] = 1'b1;
    wait_fault();
    tick(60);
    check("R8 fault flag", int'(fault_n_o), 0);
    check("R8 stays connected", int'(connect_o), 1);
    check("R8 no clocking", falls_scl[0] - base_scl[0], 0);
    hold_sda[0] = 1'b0; tick(60);
    cur_req = "R9";
    check("R9 fault held without rejoin", int'(fault_n_o), 0);
    rejoin_seq(4'b0001);
    check("R9 fault cleared by rejoin", int'(fault_n_o), 1);

    // reconnect in the middle of recovery
    cur_req = "R10";
    disc = 1'b1; tick(5);
    hold_sda[0] = 1'b1;
    wait_fault();
    tick(8);
    check("R10 still clocking", int'(connect_o), 0);
    hold_sda[0] = 1'b0;
    en = '0; tick(2);
    en = 4'b0001; tick(5);
    check("R10 connect restored", int'(connect_o), 1);
    check("R10 fault cleared", int'(fault_n_o), 1);
    check("R10 scl released", int'(scl_rel_o), 15);
    check("R10 sda released", int'(sda_rel_o), 15);
    tick(20);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule